// File: doc/BRIEF.md
# Eye Mask Error Detector

This block counts mask violations in a received serial stream that has already been sliced and deserialized. Each word cycle it receives, for every lane, four bits: the result of a high-threshold comparator and a low-threshold comparator, each taken at an early sampling phase and again at a late sampling phase. The early pair and the late pair each cover one half of the eye. When the two thresholds at one phase disagree, the transition passed inside the rectangular mask, and that is counted as one violation.

A side select picks which half of the eye feeds the count: early, late or both. The violation count is pre-scaled by M = 1, 4, 16 or 64. Each time the pre-scaler wraps, a toggle flips. The toggle (or, in pulse mode, a "wrapped since last time" flag) is retimed onto a slow output clock, made by a fixed power-of-two division of the word clock, so that an ordinary frequency counter off chip can read the mask error rate. A controller steps the thresholds and phases outside this block and reads the error frequency at each mask setting.

Top module: `eye_mask_err_det`

## Requirements
- R1: While `rst` is high at a clock edge, every register is cleared. After that edge `err_out` and `clk_out` are 0, and errors presented during reset are never counted.
- R2: In lane i the early error bit is `hi_early[i] ^ lo_early[i]` and the late error bit is `hi_late[i] ^ lo_late[i]`. Lanes with equal threshold results contribute nothing.
- R3: `side_sel[0]` enables the early errors and `side_sel[1]` enables the late errors. With `side_sel` = 2'b00 nothing is counted.
- R4: With `side_sel` = 2'b11, a lane flagging on both sides in one cycle adds two to the count. The pre-scaler accepts up to 2*LANES increments per cycle.
- R5: `div_sel` = 0, 1, 2, 3 selects M = 1, 4, 16, 64. In toggle mode (`pulse_mode` = 0), after N counted violations the internal toggle equals floor(N/M) mod 2.
- R6: `clk_out` has period 2^OUT_DIV_LOG2 word clocks and 50 % duty. It rises on the edge at which the internal slow counter reaches half its range.
- R7: `err_out` changes only on the edge at which `clk_out` rises.
- R8: In pulse mode (`pulse_mode` = 1), at each rise of `clk_out` the output `err_out` becomes 1 if the pre-scaler wrapped at least once during the previous slow period, and 0 otherwise.
- R9: Samples taken at edge k are counted by the pre-scaler at edge k+2. The output picks up the result at the first rise of `clk_out` after that.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock (deserialized rate) |
| rst | input | 1 | Synchronous active-high reset |
| hi_early | input | LANES | High-threshold result at the early phase, one bit per lane |
| lo_early | input | LANES | Low-threshold result at the early phase |
| hi_late | input | LANES | High-threshold result at the late phase |
| lo_late | input | LANES | Low-threshold result at the late phase |
| side_sel | input | 2 | Bit 0 enables early errors, bit 1 enables late errors |
| div_sel | input | 2 | Pre-scale select, M = 4^div_sel |
| pulse_mode | input | 1 | 0: toggle output, 1: wrapped-since-last-tick pulse |
| err_out | output | 1 | Error stream retimed to the slow clock |
| clk_out | output | 1 | Slow output clock |

## Verification
A wrong residue in the pre-scaler, or a lost or doubled increment, shows up as the toggle being in the wrong phase. It becomes visible on `err_out` at the next rise of `clk_out`, so within one slow period, and the error stays there because the toggle parity never heals by itself. A wrong side mask or a wrong XOR pairing changes the count at the first violating sample, and the mismatch appears one slow period later. A counter fault in the slow divider shifts `clk_out` at once, because that output is compared on every word cycle.

// File: rtl/emd_pkg.sv
package emd_pkg;
  localparam int SEL_W     = 2;
  localparam int STEP_LOG2 = 2;
  localparam int MAX_SEL   = (1 << SEL_W) - 1;
  localparam int ACC_W     = STEP_LOG2 * MAX_SEL;

  function automatic int sum_width(input int lanes);
    return $clog2(2 * lanes + 1);
  endfunction
endpackage

// File: rtl/emd_retime.sv
module emd_retime #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/emd_combine.sv
module emd_combine
  import emd_pkg::*;
#(
  parameter int LANES = 16,
  localparam int SUM_W = sum_width(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] hi_e,
  input  logic [LANES-1:0] lo_e,
  input  logic [LANES-1:0] hi_l,
  input  logic [LANES-1:0] lo_l,
  input  logic [1:0]       side_sel,
  output logic [SUM_W-1:0] err_sum
);
  logic [LANES-1:0] e_err;
  logic [LANES-1:0] l_err;
  logic [SUM_W-1:0] cnt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign e_err[i] = (hi_e[i] ^ lo_e[i]) & side_sel[0];
    assign l_err[i] = (hi_l[i] ^ lo_l[i]) & side_sel[1];
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      cnt = cnt + SUM_W'(e_err[i]) + SUM_W'(l_err[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_sum <= '0;
    else     err_sum <= cnt;
  end
endmodule

// File: rtl/emd_divider.sv
module emd_divider
  import emd_pkg::*;
#(
  parameter int SUM_W = 5,
  localparam int TOT_W = ((ACC_W > SUM_W) ? ACC_W : SUM_W) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SUM_W-1:0] err_sum,
  input  logic [1:0]       div_sel,
  output logic [ACC_W-1:0] acc_q,
  output logic             tog_q,
  output logic             wrap_now
);
  logic [TOT_W-1:0] total;
  logic [TOT_W-1:0] wraps;
  logic [TOT_W-1:0] mask;
  int unsigned      shamt;

  always_comb begin
    shamt    = STEP_LOG2 * int'(div_sel);
    total    = TOT_W'(acc_q) + TOT_W'(err_sum);
    wraps    = total >> shamt;
    mask     = (TOT_W'(1) << shamt) - TOT_W'(1);
    wrap_now = |wraps;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      tog_q <= 1'b0;
    end else begin
      acc_q <= ACC_W'(total & mask);
      tog_q <= tog_q ^ wraps[0];
    end
  end
endmodule

// File: rtl/emd_slow_out.sv
module emd_slow_out #(
  parameter int DIV_LOG2 = 10,
  localparam logic [DIV_LOG2-1:0] TICK_AT = DIV_LOG2'((1 << (DIV_LOG2 - 1)) - 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tog,
  input  logic wrap_now,
  input  logic pulse_mode,
  output logic err_out,
  output logic clk_out
);
  logic [DIV_LOG2-1:0] div_q;
  logic                pend_q;
  logic                tick;

  assign tick    = (div_q == TICK_AT);
  assign clk_out = div_q[DIV_LOG2-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      pend_q  <= 1'b0;
      err_out <= 1'b0;
    end else begin
      div_q <= div_q + DIV_LOG2'(1);
      if (tick) begin
        err_out <= pulse_mode ? pend_q : tog;
        pend_q  <= wrap_now;
      end else begin
        pend_q  <= pend_q | wrap_now;
      end
    end
  end
endmodule

// File: rtl/eye_mask_err_det.sv
module eye_mask_err_det
  import emd_pkg::*;
#(
  parameter int LANES        = 16,
  parameter int OUT_DIV_LOG2 = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] hi_early,
  input  logic [LANES-1:0] lo_early,
  input  logic [LANES-1:0] hi_late,
  input  logic [LANES-1:0] lo_late,
  input  logic [1:0]       side_sel,
  input  logic [1:0]       div_sel,
  input  logic             pulse_mode,
  output logic             err_out,
  output logic             clk_out
);
  localparam int SUM_W = sum_width(LANES);

  logic [4*LANES-1:0] raw;
  logic [4*LANES-1:0] rt;
  logic [SUM_W-1:0]   err_sum;
  logic [ACC_W-1:0]   acc_q;
  logic               tog_q;
  logic               wrap_now;

  assign raw = {hi_early, lo_early, hi_late, lo_late};

  emd_retime #(.W(4*LANES)) u_retime (
    .clk(clk), .rst(rst), .d(raw), .q(rt)
  );

  emd_combine #(.LANES(LANES)) u_combine (
    .clk(clk), .rst(rst),
    .hi_e(rt[4*LANES-1:3*LANES]), .lo_e(rt[3*LANES-1:2*LANES]),
    .hi_l(rt[2*LANES-1:LANES]),   .lo_l(rt[LANES-1:0]),
    .side_sel(side_sel), .err_sum(err_sum)
  );

  emd_divider #(.SUM_W(SUM_W)) u_divider (
    .clk(clk), .rst(rst), .err_sum(err_sum), .div_sel(div_sel),
    .acc_q(acc_q), .tog_q(tog_q), .wrap_now(wrap_now)
  );

  emd_slow_out #(.DIV_LOG2(OUT_DIV_LOG2)) u_out (
    .clk(clk), .rst(rst), .tog(tog_q), .wrap_now(wrap_now),
    .pulse_mode(pulse_mode), .err_out(err_out), .clk_out(clk_out)
  );
endmodule

// File: rtl/emd_chk.sv
module emd_chk
  import emd_pkg::*;
#(
  parameter int LANES = 16,
  localparam int SUM_W = sum_width(LANES)
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       side_sel,
  input logic [1:0]       div_sel,
  input logic [SUM_W-1:0] err_sum,
  input logic [ACC_W-1:0] acc_q,
  input logic             err_out,
  input logic             clk_out
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!err_out && !clk_out && err_sum == '0));

  // R7
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(clk_out) |-> $stable(err_out));

  // R5
  residue_chk: assert property (@(posedge clk) disable iff (rst)
    (ACC_W + 1)'(acc_q) < ((ACC_W + 1)'(1) << (STEP_LOG2 * int'($past(div_sel)))));

  // R3
  side_off_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(side_sel) == 2'b00) |-> (err_sum == '0));

  // R4
  sum_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(err_sum) <= 2 * LANES);
endmodule

bind eye_mask_err_det emd_chk #(.LANES(LANES)) u_emd_chk (
  .clk(clk), .rst(rst), .side_sel(side_sel), .div_sel(div_sel),
  .err_sum(err_sum), .acc_q(acc_q), .err_out(err_out), .clk_out(clk_out)
);

// File: tb/tb_eye_mask_err_det.sv
module tb_eye_mask_err_det;
  localparam int LANES = 4;
  localparam int DL2   = 3;
  localparam int HALF  = 1 << (DL2 - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES-1:0] he = '0, le = '0, hl = '0, ll = '0;
  logic [1:0] side_sel = 2'b00, div_sel = 2'b00;
  logic pulse_mode = 1'b0;
  logic err_out, clk_out;

  int checks = 0, fails = 0;
  bit done = 0;
  bit chk_en = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  eye_mask_err_det #(.LANES(LANES), .OUT_DIV_LOG2(DL2)) dut (
    .clk(clk), .rst(rst), .hi_early(he), .lo_early(le), .hi_late(hl), .lo_late(ll),
    .side_sel(side_sel), .div_sel(div_sel), .pulse_mode(pulse_mode),
    .err_out(err_out), .clk_out(clk_out)
  );

  // Independent model: cumulative count, quotient parity, wrap-since-tick.
  int m_tot, m_s2, m_div;
  logic [4*LANES-1:0] m_s1;
  bit m_pend, m_out;

  function automatic int errsum(input logic [4*LANES-1:0] s, input logic [1:0] sel);
    int n = 0;
    for (int i = 0; i < LANES; i++) begin
      if (sel[0] && (s[3*LANES+i] != s[2*LANES+i])) n++;
      if (sel[1] && (s[LANES+i] != s[i])) n++;
    end
    return n;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_tot = 0; m_s2 = 0; m_div = 0; m_s1 = '0; m_pend = 0; m_out = 0;
    end else begin
      int m, oq, nq;
      bit tick, wrapped;
      m = 1 << (2 * div_sel);
      tick = ((m_div % (1 << DL2)) == HALF - 1);
      oq = m_tot / m;
      nq = (m_tot + m_s2) / m;
      wrapped = (nq != oq);
      if (tick) begin
        m_out = pulse_mode ? m_pend : oq[0];
        m_pend = wrapped;
      end else begin
        m_pend = m_pend | wrapped;
      end
      m_tot = m_tot + m_s2;
      m_s2 = errsum(m_s1, side_sel);
      m_s1 = {he, le, hl, ll};
      m_div = m_div + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && !done) begin
      // R6: slow clock shape
      check(clk_out == (((m_div % (1 << DL2)) >= HALF) ? 1'b1 : 1'b0), "R6",
            clk_out, ((m_div % (1 << DL2)) >= HALF));
      // R7 R9 plus the scenario requirement
      check(err_out == m_out, {tag, " R7 R9"}, err_out, m_out);
    end
  end

  task automatic do_reset();
    rst = 1'b1;
    he = '1; le = '0; hl = '1; ll = '0;   // errors during reset must be dropped
    repeat (3) @(negedge clk);
    // R1: outputs cleared during reset
    check(err_out == 1'b0 && clk_out == 1'b0, "R1", {err_out, clk_out}, 0);
    rst = 1'b0;
    he = '0; le = '0; hl = '0; ll = '0;
  endtask

  task automatic run(input int cycles, input int density);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      begin
        logic [LANES-1:0] a, b, ea, eb;
        a = LANES'($urandom);
        b = LANES'($urandom);
        ea = '0; eb = '0;
        for (int i = 0; i < LANES; i++) begin
          if (($urandom % 16) < density) ea[i] = 1'b1;
          if (($urandom % 16) < density) eb[i] = 1'b1;
        end
        he = a; le = a ^ ea; hl = b; ll = b ^ eb;
      end
    end
  endtask

  initial begin
    @(negedge clk);
    chk_en = 1;
    do_reset();
    // R1: after reset, errors held during reset produced nothing
    tag = "R1";
    run(16, 0);
    // R2: equal thresholds never count, even with every side enabled
    tag = "R2";
    side_sel = 2'b11; div_sel = 2'b00;
    for (int c = 0; c < 24; c++) begin
      @(negedge clk);
      he = LANES'($urandom); le = he; hl = LANES'($urandom); ll = hl;
    end
    run(16, 0);
    for (int pm = 0; pm < 2; pm++) begin
      for (int ds = 0; ds < 4; ds++) begin
        for (int ss = 0; ss < 4; ss++) begin
          for (int dn = 1; dn < 16; dn += 7) begin
            pulse_mode = pm[0]; div_sel = ds[1:0]; side_sel = ss[1:0];
            do_reset();
            if (pm == 1)        tag = "R8";
            else if (ss == 3)   tag = "R4 R5";
            else if (ss == 0)   tag = "R3";
            else                tag = "R3 R5";
            run(160, dn);
            run(24, 0);
          end
        end
      end
    end
    // R4: a single lane flagging on both sides, M=1: two wraps, toggle parity unchanged
    pulse_mode = 1'b0; div_sel = 2'b00; side_sel = 2'b11;
    do_reset();
    tag = "R4";
    @(negedge clk);
    he = 4'b0001; le = 4'b0000; hl = 4'b0001; ll = 4'b0000;
    @(negedge clk);
    he = '0; hl = '0;
    repeat (2 * (1 << DL2)) @(negedge clk);
    check(err_out == 1'b0, "R4 double count", err_out, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule